// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus-facing front end of a byte-addressed nonvolatile memory of 256 to 2048 bytes that sits on a two-wire serial bus as a slave. It oversamples the clock and data lines with a fast system clock. It recognises bus start and stop events and takes in the 8-bit device byte, comparing it against the strapped hardware address. It acknowledges by pulling the data line low through an open-drain enable. It then either loads a word address and writes each following byte to a storage port, or streams bytes out of that port. The memory array itself lives outside, behind a simple synchronous port.

The density parameter decides how the three selectable bits of the device byte are used. Some are compared against hardware strap pins, so several devices can share one bus. The remaining low-order bits become the upper memory address bits and select one of 1, 2, 4 or 8 blocks of 256 bytes. The storage is assumed to return `mem_rdata` one system clock after `mem_addr` settles.

Top module: `twi_mem_slave`

## Requirements
- R1: A start (data falling while clock is high) restarts device-byte reception from any state, including in the middle of a transfer. This makes a repeated start without an intervening stop valid. A stop is data rising while clock is high.
- R2: Out of reset, and after any stop, the slave ignores clocked bus traffic: it gives no acknowledge and makes no write until it sees a start.
- R3: The device byte is sent MSB first: fixed bits 1010, then three select bits, then a direction bit (1 = read). On a match, the slave holds `sda_oe` = 1 during the ninth clock. On a mismatch it never drives the line before the next start.
- R4: The number of page bits is log2(MEM_BYTES) - 8, which is 0, 1, 2 or 3. The page bits are the low-order select bits (device-byte bit 1 upward). Only the select bits above them are compared with `hw_addr`, where device-byte bit 3 is compared with `hw_addr[2]` and bit 1 with `hw_addr[0]`. A matching device byte replaces the upper address bits with its page bits.
- R5: In a write, the byte after the device byte sets the low 8 address bits. Every following byte produces a one-cycle `mem_we` at the current address and is acknowledged. The address then increments, carrying into the page bits and wrapping at MEM_BYTES.
- R6: In a read, the slave sends the byte at the current address MSB first, advances the address, and sends the next byte whenever the master acknowledges.
- R7: When the master does not acknowledge a read byte, the slave releases the data line and drives nothing more until the next start or stop.
- R8: `sda_oe` only becomes 1 in response to a falling clock edge, so the slave never changes the line while the clock is high.
- R9: After reset, `sda_oe` and `mem_we` are 0 and `mem_addr` is 0.
- R10: A read that is not preceded by a word address continues from the address after the last byte transferred, with the upper bits taken from the new device byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Open-drain enable; 1 pulls the data line low |
| hw_addr | input | 3 | Strapped device select pins |
| mem_addr | output | log2(MEM_BYTES) | Storage address |
| mem_we | output | 1 | One-cycle storage write strobe |
| mem_wdata | output | 8 | Storage write data |
| mem_rdata | input | 8 | Storage read data, one cycle after `mem_addr` |

## Verification
Faults in this block can be seen at the pins:
- A bit counter or state register that is off by one shows up as an acknowledge in the wrong ninth-clock slot. This is visible within the same byte.
- A wrong address register shows up as a `mem_we` at an unexpected address, or as a read byte that does not match the shadow contents. This is visible in the very next data byte.
- A matcher with the wrong density split either acknowledges a foreign device byte or ignores its own, on the first byte of a transfer.
- A slave that keeps driving after a missing acknowledge corrupts the next eight clocks, which the master would otherwise read back as all ones.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam logic [3:0] DEV_PREAMBLE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT_STOP
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_addr_match.sv
module twi_addr_match #(
  parameter int PAGE_BITS = 3
) (
  input  logic [6:0] dev_bits,
  input  logic [2:0] hw_addr,
  output logic       hit,
  output logic [2:0] page
);
  import twi_pkg::*;
  localparam logic [2:0] CARE = 3'(3'b111 << PAGE_BITS);

  logic [2:0] sel;
  assign sel  = dev_bits[2:0];
  assign hit  = (dev_bits[6:3] == DEV_PREAMBLE) && (((sel ^ hw_addr) & CARE) == 3'b000);
  assign page = sel & ~CARE;
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              hit,
  input  logic [2:0]        page,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        rx_byte,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata
);
  import twi_pkg::*;

  twi_state_e        state;
  logic [3:0]        cnt;
  logic [7:0]        rx_sr, tx_sr;
  logic              rd_mode, acked;
  logic [ADDR_W-1:0] addr;

  assign rx_byte  = rx_sr;
  assign mem_addr = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      rx_sr     <= '0;
      tx_sr     <= '1;
      rd_mode   <= 1'b0;
      acked     <= 1'b0;
      addr      <= '0;
      sda_oe    <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (mem_we) addr <= addr + ADDR_W'(1);
      if (start_det) begin
        state  <= ST_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise) begin
              rx_sr <= {rx_sr[6:0], sda_lvl};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == ST_DEV) begin
                if (hit) begin
                  sda_oe  <= 1'b1;
                  rd_mode <= rx_sr[0];
                  addr    <= (addr & ADDR_W'(8'hFF)) | ADDR_W'({page, 8'h00});
                  state   <= ST_DEV_ACK;
                end else begin
                  state <= ST_WAIT_STOP;
                end
              end else if (state == ST_WADDR) begin
                sda_oe     <= 1'b1;
                addr[7:0]  <= rx_sr;
                state      <= ST_WADDR_ACK;
              end else begin
                sda_oe    <= 1'b1;
                mem_we    <= 1'b1;
                mem_wdata <= rx_sr;
                state     <= ST_WDATA_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                tx_sr  <= {mem_rdata[6:0], 1'b1};
                sda_oe <= ~mem_rdata[7];
                addr   <= addr + ADDR_W'(1);
                cnt    <= 4'd1;
                state  <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= ST_WADDR;
              end
            end
          end
          ST_WADDR_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~tx_sr[7];
                tx_sr  <= {tx_sr[6:0], 1'b1};
                cnt    <= cnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              acked <= ~sda_lvl;
            end else if (scl_fall) begin
              if (acked) begin
                tx_sr  <= {mem_rdata[6:0], 1'b1};
                sda_oe <= ~mem_rdata[7];
                addr   <= addr + ADDR_W'(1);
                cnt    <= 4'd1;
                state  <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WAIT_STOP;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  // R8: the line is only pulled low after a falling clock edge
  assert_oe_on_scl_low_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));
  // R2: a stop leaves the slave idle and silent
  assert_stop_idles_R2: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE) && !sda_oe);
  // R1: a start always restarts device-byte reception
  assert_start_restarts_R1: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_DEV));
  // R5: each stored byte is acknowledged
  assert_write_acked_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> sda_oe);
  // R5: the write strobe lasts one cycle
  assert_we_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int MEM_BYTES   = 2048,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         scl_i,
  input  logic                         sda_i,
  output logic                         sda_oe,
  input  logic [2:0]                   hw_addr,
  output logic [$clog2(MEM_BYTES)-1:0] mem_addr,
  output logic                         mem_we,
  output logic [7:0]                   mem_wdata,
  input  logic [7:0]                   mem_rdata
);
  localparam int ADDR_W    = $clog2(MEM_BYTES);
  localparam int PAGE_BITS = ADDR_W - 8;

  logic       sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic       hit;
  logic [2:0] page;
  logic [7:0] rx_byte;

  initial begin
    assert_density_range_R4: assert (PAGE_BITS >= 0 && PAGE_BITS <= 3 && SYNC_STAGES >= 2);
  end

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_addr_match #(.PAGE_BITS(PAGE_BITS)) u_match (
    .dev_bits(rx_byte[7:1]), .hw_addr(hw_addr), .hit(hit), .page(page)
  );

  twi_slave_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .hit(hit), .page(page), .mem_rdata(mem_rdata), .rx_byte(rx_byte),
    .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );
endmodule

// File: tb/twi_mem_slave_bench.sv
`timescale 1ns/1ps
module twi_mem_slave_bench;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic scl = 1'b1, sda_m = 1'b1, sel = 1'b0;
  logic oe_a, oe_b, we_a, we_b;
  logic [10:0] addr_a;
  logic [8:0]  addr_b;
  logic [7:0]  wd_a, wd_b, rd_a, rd_b;
  logic [7:0]  mem_a [2048];
  logic [7:0]  mem_b [512];
  logic [7:0]  exp_a [2048];
  logic [7:0]  exp_b [512];

  wire scl_a = sel ? 1'b1 : scl;
  wire scl_b = sel ? scl : 1'b1;
  wire sda_a = sel ? 1'b1 : (sda_m & ~oe_a);
  wire sda_b = sel ? (sda_m & ~oe_b) : 1'b1;
  wire bus_sda = sel ? sda_b : sda_a;

  twi_mem_slave #(.MEM_BYTES(2048)) u_twi_mem_slave (
    .clk(clk), .rst(rst), .scl_i(scl_a), .sda_i(sda_a), .sda_oe(oe_a),
    .hw_addr(3'b000), .mem_addr(addr_a), .mem_we(we_a), .mem_wdata(wd_a), .mem_rdata(rd_a));

  twi_mem_slave #(.MEM_BYTES(512)) u_twi_mem_slave_small (
    .clk(clk), .rst(rst), .scl_i(scl_b), .sda_i(sda_b), .sda_oe(oe_b),
    .hw_addr(3'b100), .mem_addr(addr_b), .mem_we(we_b), .mem_wdata(wd_b), .mem_rdata(rd_b));

  always @(posedge clk) begin
    if (we_a) mem_a[addr_a] <= wd_a;
    if (we_b) mem_b[addr_b] <= wd_b;
    rd_a <= mem_a[addr_a];
    rd_b <= mem_b[addr_b];
  end

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct { bit inst; int addr; int data; } wr_t;
  wr_t wq[$];

  task automatic expect_wr(bit inst, int a, int d);
    wr_t it;
    it.inst = inst; it.addr = a; it.data = d;
    wq.push_back(it);
    if (inst) exp_b[a] = 8'(d); else exp_a[a] = 8'(d);
  endtask

  // monitor: compares every storage write against the queue (R5)
  always @(negedge clk) begin
    if (!rst && (we_a || we_b)) begin
      wr_t it;
      if (wq.size() == 0) begin
        chk("R5 unexpected write", we_a ? int'(addr_a) : int'(addr_b), -1);
      end else begin
        it = wq.pop_front();
        chk("R5 write instance", we_b ? 1 : 0, it.inst);
        chk("R5 write address", we_b ? int'(addr_b) : int'(addr_a), it.addr);
        chk("R5 write data", we_b ? int'(wd_b) : int'(wd_a), it.data);
      end
    end
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic v, output logic s);
    wt(H); sda_m = v; wt(H); scl = 1'b1; wt(2*H); s = bus_sda; scl = 1'b0;
  endtask

  task automatic bus_start();
    wt(H); sda_m = 1'b1; wt(H); scl = 1'b1; wt(2*H); sda_m = 1'b0; wt(2*H); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wt(H); sda_m = 1'b0; wt(H); scl = 1'b1; wt(2*H); sda_m = 1'b1; wt(2*H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_n);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, ack_n);
  endtask

  task automatic recv_byte(input bit m_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      b[i] = s;
    end
    bit_cycle(m_ack ? 1'b0 : 1'b1, s);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
  end

  initial begin
    logic a;
    logic [7:0] b;
    for (int i = 0; i < 2048; i++) begin mem_a[i] = 8'(i * 7 + 3); exp_a[i] = 8'(i * 7 + 3); end
    for (int i = 0; i < 512; i++)  begin mem_b[i] = 8'(i * 5 + 1); exp_b[i] = 8'(i * 5 + 1); end
    scl = 1'b1; sda_m = 1'b1;
    wt(5); rst = 1'b0; wt(2);
    chk("R9 reset sda_oe", oe_a, 0);
    chk("R9 reset mem_we", we_a, 0);
    chk("R9 reset mem_addr", addr_a, 0);

    // R2: traffic with no start before it
    scl = 1'b0;
    send_byte(8'hA0, a);
    chk("R2 no ack before start", a, 1);
    send_byte(8'h00, a);
    chk("R2 still silent", a, 1);
    wt(H); scl = 1'b1; wt(2*H);

    // R3/R5: write page 3, crossing into page 4
    bus_start();
    send_byte(8'b1010_011_0, a); chk("R3 device ack", a, 0);
    send_byte(8'hFE, a);         chk("R5 word address ack", a, 0);
    expect_wr(0, 11'h3FE, 8'h11); send_byte(8'h11, a); chk("R5 data ack 1", a, 0);
    expect_wr(0, 11'h3FF, 8'h22); send_byte(8'h22, a); chk("R5 data ack 2", a, 0);
    expect_wr(0, 11'h400, 8'h33); send_byte(8'h33, a); chk("R5 data ack 3 carry", a, 0);
    bus_stop();

    // R1/R6: random read through a repeated start
    bus_start();
    send_byte(8'b1010_011_0, a); chk("R3 device ack read setup", a, 0);
    send_byte(8'hFD, a);         chk("R5 word address ack", a, 0);
    bus_start();
    send_byte(8'b1010_011_1, a); chk("R1 ack after repeated start", a, 0);
    recv_byte(1, b); chk("R6 read byte 0", b, exp_a[11'h3FD]);
    recv_byte(1, b); chk("R6 read byte 1", b, exp_a[11'h3FE]);
    recv_byte(1, b); chk("R6 read byte 2", b, exp_a[11'h3FF]);
    recv_byte(0, b); chk("R6 read byte 3 carry", b, exp_a[11'h400]);
    // R7: no acknowledge, so the slave must stay off the line
    recv_byte(1, b); chk("R7 released after nack", b, 8'hFF);
    bus_stop();

    // R10: current-address read, upper bits from new page 5
    bus_start();
    send_byte(8'b1010_101_1, a); chk("R10 device ack", a, 0);
    recv_byte(0, b); chk("R10 current address read", b, exp_a[11'h501]);
    bus_stop();

    // R2: after a stop, no response without a start
    scl = 1'b0;
    send_byte(8'b1010_000_0, a); chk("R2 silent after stop", a, 1);
    wt(H); scl = 1'b1; wt(2*H);

    // R5: wrap at the top of the array
    bus_start();
    send_byte(8'b1010_111_0, a); chk("R3 device ack page 7", a, 0);
    send_byte(8'hFF, a);         chk("R5 word address ack", a, 0);
    expect_wr(0, 11'h7FF, 8'hA5); send_byte(8'hA5, a); chk("R5 data ack top", a, 0);
    expect_wr(0, 11'h000, 8'h5A); send_byte(8'h5A, a); chk("R5 data ack wrap", a, 0);
    bus_stop();

    // R4: 512-byte instance, hw_addr 100, compares bits 3:2, bit 1 is page
    sel = 1'b1; wt(4*H);
    bus_start();
    send_byte(8'b1010_001_0, a); chk("R4 mismatched pins no ack", a, 1);
    send_byte(8'h10, a);         chk("R3 silent after mismatch", a, 1);
    bus_stop();
    bus_start();
    send_byte(8'b1010_101_0, a); chk("R4 matched pins ack", a, 0);
    send_byte(8'h10, a);         chk("R4 word address ack", a, 0);
    expect_wr(1, 9'h110, 8'hC3); send_byte(8'hC3, a); chk("R4 data ack page 1", a, 0);
    bus_start();
    send_byte(8'b1010_100_0, a); chk("R4 page 0 ack", a, 0);
    send_byte(8'h10, a);         chk("R4 word address ack", a, 0);
    bus_start();
    send_byte(8'b1010_100_1, a); chk("R4 page 0 read ack", a, 0);
    recv_byte(0, b); chk("R4 page 0 read", b, exp_b[9'h010]);
    bus_stop();
    bus_start();
    send_byte(8'b1010_101_0, a); chk("R4 page 1 ack", a, 0);
    send_byte(8'h10, a);         chk("R4 word address ack", a, 0);
    bus_start();
    send_byte(8'b1010_101_1, a); chk("R4 page 1 read ack", a, 0);
    recv_byte(0, b); chk("R4 page 1 read", b, exp_b[9'h110]);
    bus_stop();

    wt(20);
    chk("R5 all writes seen", wq.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule